// File: doc/BRIEF.md
# SPI Boot EEPROM Reader with Address-Width Probe

This block is the SPI master that pulls boot data out of a serial EEPROM. The memory may take either a three-byte or a two-byte address, and the block finds out which one on its own. On the first request after reset, it reads four bytes at a fixed probe offset using a three-byte address and looks for the ASCII word "BOOT". If those bytes do not match, it releases chip select, waits, and repeats the probe with a two-byte address. The width that produced the signature is latched and reported. If neither width produces it, the block reports a failure.

Once a width is known, each start request reads a given number of bytes from a given address using that width. Every byte goes to a downstream consumer on a byte port with a single-cycle valid strobe. Each transfer is the plain read opcode, then the address, then the data. The bus runs in SPI mode 0. The serial clock comes from the system clock through a divider parameter.

Top module: `spi_boot_reader`

## Requirements
- R1: After reset, chip select is high, SCK is low, and done, fail, busy, rd_valid and mode_valid are all 0.
- R2: SCK idles low whenever chip select is high. While chip select is low, MOSI changes only in the cycle where SCK falls. MISO is captured on the rising SCK edge.
- R3: Every transfer begins with the byte 0x03, MSB first. The address follows at once, MSB first: 24 bits (rd_addr[23:0]) in wide mode, or 16 bits (rd_addr[15:0]) in narrow mode.
- R4: With no width latched, a start request first reads 4 bytes at SIG_OFFSET (default 0x40) using a 24-bit address, in a single chip-select window. If the bytes are 0x42, 0x4F, 0x4F, 0x54 in that order, the block pulses done with fail at 0 and sets mode_valid=1 and mode_is24=1.
- R5: If the wide probe misses, chip select stays high for at least one full SCK period (2*HALF_DIV system cycles). The probe then repeats with a 16-bit address. A match sets mode_valid=1 and mode_is24=0.
- R6: If both probes miss, fail pulses in the same cycle as done and mode_valid stays 0. The next start request runs the whole probe again.
- R7: MISO is ignored during the opcode and address bits. The first data bit is the one captured on SCK rising edge number 32 (wide) or 24 (narrow), counting from 0.
- R8: After a width is latched, start reads rd_len bytes from rd_addr in that width, in one chip-select window. Each byte appears on rd_data with a one-cycle rd_valid. rd_valid never pulses during a probe.
- R9: A read request with rd_len=0 pulses done without asserting chip select.
- R10: Each high phase of SCK lasts exactly HALF_DIV system cycles.
- R11: A start pulse while busy is 1 has no effect: it starts no extra transfer and does not change the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request: probe if no width is known, otherwise read |
| rd_addr | input | 24 | Start address of a read request |
| rd_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | A probe or read is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Pulses with done when no probe found the signature |
| mode_valid | output | 1 | A width has been latched |
| mode_is24 | output | 1 | 1: 24-bit addressing, 0: 16-bit addressing |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Received data byte |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The embedded properties assume a single-cycle start, and they assume the bench holds rd_addr and rd_len steady in the cycle start is high. They assume nothing about MISO. The bench memory model drives random bits on MISO during every opcode and address phase. It changes MISO only on falling SCK, seen from the system clock, so each captured bit stays stable over a full half period. Start pulses during busy, zero-length reads, and addresses that wrap the memory are applied on purpose. Random addresses and lengths from a seeded generator stay within 24-bit addresses and 1 to 6 bytes.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam int         HDR_W    = 32;
    localparam int         WIDE_HDR = 32;
    localparam int         NARW_HDR = 24;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SHIFT,
        E_GAP
    } eng_state_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_PROBE_WIDE,
        C_PROBE_NARROW,
        C_FETCH
    } ctl_state_t;

    typedef struct packed {
        logic [HDR_W-1:0] bits;   // left-aligned opcode + address
        logic             wide;   // 1: 24-bit address follows the opcode
    } xfer_hdr_t;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h42;
            2'd1:    return 8'h4F;
            2'd2:    return 8'h4F;
            default: return 8'h54;
        endcase
    endfunction

    function automatic xfer_hdr_t build_hdr(input logic wide, input logic [23:0] addr);
        xfer_hdr_t h;
        h.wide = wide;
        if (wide) h.bits = {OP_READ, addr};
        else      h.bits = {OP_READ, addr[15:0], 8'h00};
        return h;
    endfunction

endpackage

// File: rtl/sck_divider.sv
module sck_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = en;
        end else begin : g_count
            localparam int CW = $clog2(HALF_DIV);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !en)                   cnt <= '0;
                else if (cnt == CW'(HALF_DIV - 1)) cnt <= '0;
                else                              cnt <= cnt + 1'b1;
            end

            assign tick = en && (cnt == CW'(HALF_DIV - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);  // R10
        end
    endgenerate
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_boot_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  xfer_hdr_t        hdr,
    input  logic [LEN_W-1:0] nbytes,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int CNT_W = LEN_W + 4;

    eng_state_t       st;
    logic             tick;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] total;
    logic             wide_r;
    logic [HDR_W-1:0] tx_sr;
    logic [7:0]       rx_sr;
    logic             gap_half;
    logic             in_data;

    sck_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (st != E_IDLE),
        .tick (tick)
    );

    // The header is a whole number of bytes, so byte phase is just bit_cnt[2:0]
    assign in_data = bit_cnt >= (wide_r ? CNT_W'(WIDE_HDR) : CNT_W'(NARW_HDR));
    assign mosi    = tx_sr[HDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= E_IDLE;
            sck      <= 1'b0;
            cs_n     <= 1'b1;
            tx_sr    <= '0;
            rx_sr    <= '0;
            bit_cnt  <= '0;
            total    <= '0;
            wide_r   <= 1'b0;
            gap_half <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            done     <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            done     <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (go) begin
                        cs_n    <= 1'b0;
                        sck     <= 1'b0;
                        tx_sr   <= hdr.bits;
                        wide_r  <= hdr.wide;
                        bit_cnt <= '0;
                        total   <= (hdr.wide ? CNT_W'(WIDE_HDR) : CNT_W'(NARW_HDR))
                                   + CNT_W'({nbytes, 3'b000});
                        st      <= E_SHIFT;
                    end
                end
                E_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck     <= 1'b1;
                            rx_sr   <= {rx_sr[6:0], miso};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (in_data && bit_cnt[2:0] == 3'd7) begin
                                rx_valid <= 1'b1;
                                rx_data  <= {rx_sr[6:0], miso};
                            end
                        end else begin
                            sck <= 1'b0;
                            if (bit_cnt == total) begin
                                cs_n     <= 1'b1;
                                gap_half <= 1'b0;
                                st       <= E_GAP;
                            end else begin
                                tx_sr <= {tx_sr[HDR_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                E_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            done <= 1'b1;
                            st   <= E_IDLE;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);  // R2
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && !$stable(mosi)) |-> $fell(sck));  // R2
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        done |-> cs_n);  // R5
    AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(!cs_n));  // R7
endmodule

// File: rtl/boot_probe_ctrl.sv
module boot_probe_ctrl
    import spi_boot_pkg::*;
#(
    parameter int          LEN_W      = 8,
    parameter logic [23:0] SIG_OFFSET = 24'h000040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [23:0]      rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    output logic             eng_go,
    output xfer_hdr_t        eng_hdr,
    output logic [LEN_W-1:0] eng_nbytes,
    input  logic             eng_rx_valid,
    input  logic [7:0]       eng_rx_data,
    input  logic             eng_done,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             mode_valid,
    output logic             mode_is24,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    localparam logic [LEN_W-1:0] SIG_LEN = LEN_W'(4);

    ctl_state_t st;
    logic [1:0] sig_idx;
    logic       sig_ok;
    logic       probing;

    assign busy    = (st != C_IDLE);
    assign probing = (st == C_PROBE_WIDE) || (st == C_PROBE_NARROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= C_IDLE;
            eng_go     <= 1'b0;
            eng_hdr    <= '0;
            eng_nbytes <= '0;
            done       <= 1'b0;
            fail       <= 1'b0;
            mode_valid <= 1'b0;
            mode_is24  <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            sig_idx    <= '0;
            sig_ok     <= 1'b0;
        end else begin
            eng_go   <= 1'b0;
            done     <= 1'b0;
            fail     <= 1'b0;
            rd_valid <= 1'b0;

            if (probing && eng_rx_valid) begin
                if (eng_rx_data != sig_byte(sig_idx)) sig_ok <= 1'b0;
                sig_idx <= sig_idx + 1'b1;
            end

            case (st)
                C_IDLE: begin
                    if (start) begin
                        if (!mode_valid) begin
                            eng_go     <= 1'b1;
                            eng_hdr    <= build_hdr(1'b1, SIG_OFFSET);
                            eng_nbytes <= SIG_LEN;
                            sig_idx    <= '0;
                            sig_ok     <= 1'b1;
                            st         <= C_PROBE_WIDE;
                        end else if (rd_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            eng_go     <= 1'b1;
                            eng_hdr    <= build_hdr(mode_is24, rd_addr);
                            eng_nbytes <= rd_len;
                            st         <= C_FETCH;
                        end
                    end
                end
                C_PROBE_WIDE: begin
                    if (eng_done) begin
                        if (sig_ok) begin
                            mode_valid <= 1'b1;
                            mode_is24  <= 1'b1;
                            done       <= 1'b1;
                            st         <= C_IDLE;
                        end else begin
                            eng_go     <= 1'b1;
                            eng_hdr    <= build_hdr(1'b0, SIG_OFFSET);
                            eng_nbytes <= SIG_LEN;
                            sig_idx    <= '0;
                            sig_ok     <= 1'b1;
                            st         <= C_PROBE_NARROW;
                        end
                    end
                end
                C_PROBE_NARROW: begin
                    if (eng_done) begin
                        done <= 1'b1;
                        st   <= C_IDLE;
                        if (sig_ok) begin
                            mode_valid <= 1'b1;
                            mode_is24  <= 1'b0;
                        end else begin
                            fail <= 1'b1;
                        end
                    end
                end
                C_FETCH: begin
                    if (eng_rx_valid) begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rx_data;
                    end
                    if (eng_done) begin
                        done <= 1'b1;
                        st   <= C_IDLE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);  // R6
    AST_FAIL_NO_MODE: assert property (@(posedge clk) disable iff (rst)
        fail |-> !mode_valid);  // R6
    AST_NO_DATA_IN_PROBE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> mode_valid);  // R8
    AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(mode_valid) |-> (mode_valid && $stable(mode_is24)));  // R8
    AST_GO_ONLY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        (eng_go && $past(st) == C_IDLE) |-> $past(start));  // R11
endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader
    import spi_boot_pkg::*;
#(
    parameter int          HALF_DIV   = 2,
    parameter int          LEN_W      = 8,
    parameter logic [23:0] SIG_OFFSET = 24'h000040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [23:0]      rd_addr,
    input  logic [LEN_W-1:0] rd_len,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             mode_valid,
    output logic             mode_is24,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    logic             eng_go;
    xfer_hdr_t        eng_hdr;
    logic [LEN_W-1:0] eng_nbytes;
    logic             eng_rx_valid;
    logic [7:0]       eng_rx_data;
    logic             eng_done;

    boot_probe_ctrl #(
        .LEN_W      (LEN_W),
        .SIG_OFFSET (SIG_OFFSET)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .rd_addr      (rd_addr),
        .rd_len       (rd_len),
        .eng_go       (eng_go),
        .eng_hdr      (eng_hdr),
        .eng_nbytes   (eng_nbytes),
        .eng_rx_valid (eng_rx_valid),
        .eng_rx_data  (eng_rx_data),
        .eng_done     (eng_done),
        .busy         (busy),
        .done         (done),
        .fail         (fail),
        .mode_valid   (mode_valid),
        .mode_is24    (mode_is24),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data)
    );

    spi_xfer_engine #(
        .HALF_DIV (HALF_DIV),
        .LEN_W    (LEN_W)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (eng_go),
        .hdr      (eng_hdr),
        .nbytes   (eng_nbytes),
        .rx_valid (eng_rx_valid),
        .rx_data  (eng_rx_data),
        .done     (eng_done),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .miso     (spi_miso),
        .cs_n     (spi_cs_n)
    );

    AST_NO_SELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> spi_cs_n);  // R9
endmodule

// File: tb/spi_boot_reader_test.sv
module spi_boot_reader_test;
    localparam int HALF  = 3;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [23:0]      rd_addr = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic             busy, done, fail, mode_valid, mode_is24, rd_valid;
    logic [7:0]       rd_data;
    logic             spi_sck, spi_mosi, spi_cs_n;
    logic             spi_miso = 1'b0;

    always #10 clk = ~clk;

    spi_boot_reader #(.HALF_DIV(HALF), .LEN_W(LEN_W), .SIG_OFFSET(24'h000040)) uut (
        .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .rd_len(rd_len),
        .busy(busy), .done(done), .fail(fail), .mode_valid(mode_valid),
        .mode_is24(mode_is24), .rd_valid(rd_valid), .rd_data(rd_data),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int total = 0;
    int bad = 0;

    // memory model configuration
    int ee_aw  = 24;
    bit ee_sig = 1'b1;

    int          m_n;
    logic [39:0] m_cap;
    logic [39:0] last_cap = '0;
    int          nfall, hi_run, min_gap, hi_cnt, runs;
    int          mosi_bad = 0;
    int          run_bad = 0;
    logic [7:0]  rx_q [16];
    int          rx_n;
    bit          got_done, got_fail;
    logic        p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;

    function automatic logic [7:0] mem_byte(input int unsigned a);
        int unsigned m;
        m = (ee_aw == 24) ? (a & 32'hFFFFFF) : (a & 32'hFFFF);
        if (ee_sig && m >= 32'h40 && m <= 32'h43) begin
            case (m - 32'h40)
                0:       return 8'h42;
                1, 2:    return 8'h4F;
                default: return 8'h54;
            endcase
        end
        return 8'((m * 29) ^ (m >> 8) ^ 32'hA5);
    endfunction

    // Memory model and bus monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs && !spi_cs_n) begin
                nfall++;
                if (nfall > 1 && hi_run < min_gap) min_gap = hi_run;
                m_n = 0;
                m_cap = '0;
                spi_miso = 1'($urandom);
            end
            if (spi_cs_n) hi_run++; else hi_run = 0;

            if (!spi_cs_n && !p_sck && spi_sck) begin
                if (m_n < 8 + ee_aw) m_cap = {m_cap[38:0], spi_mosi};
                m_n++;
                if (m_n == 8 + ee_aw) last_cap = m_cap;
            end
            if (!spi_cs_n && p_sck && !spi_sck) begin
                if (m_n >= 8 + ee_aw) begin
                    int unsigned base, idx, bit_i;
                    logic [7:0]  bv;
                    base  = (ee_aw == 24) ? int'(m_cap[23:0]) : int'(m_cap[15:0]);
                    idx   = (m_n - (8 + ee_aw)) / 8;
                    bit_i = 7 - ((m_n - (8 + ee_aw)) % 8);
                    bv    = mem_byte(base + idx);
                    spi_miso = bv[bit_i];
                end else begin
                    spi_miso = 1'($urandom);   // junk during opcode/address
                end
            end

            if (!spi_cs_n && !p_cs && spi_mosi !== p_mosi && !(p_sck && !spi_sck))
                mosi_bad++;

            if (spi_sck) hi_cnt++;
            else if (p_sck) begin
                runs++;
                if (hi_cnt != HALF) run_bad++;
                hi_cnt = 0;
            end

            if (rd_valid && rx_n < 16) begin
                rx_q[rx_n] = rd_data;
                rx_n++;
            end
            if (done) begin
                got_done = 1'b1;
                got_fail = fail;
            end
        end
        p_cs   = spi_cs_n;
        p_sck  = spi_sck;
        p_mosi = spi_mosi;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_op(input logic [23:0] a, input int len);
        int t;
        nfall = 0; min_gap = 1000000; rx_n = 0; got_done = 0; got_fail = 0;
        @(negedge clk);
        rd_addr = a;
        rd_len  = LEN_W'(len);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!got_done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (!got_done) check("R8", "request never finished", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_hdr(input string req, input logic [23:0] a);
        if (ee_aw == 24) check(req, "opcode+24b address on MOSI", longint'(last_cap[31:0]), longint'({8'h03, a}));
        else             check(req, "opcode+16b address on MOSI", longint'(last_cap[23:0]), longint'({8'h03, a[15:0]}));
    endtask

    task automatic chk_read(input logic [23:0] a, input int len);
        run_op(a, len);
        check("R8", "byte count", rx_n, len);
        for (int i = 0; i < len; i++)
            check("R7", "data byte", longint'(rx_q[i]), longint'(mem_byte(int'(a) + i)));
        check("R8", "single select window", nfall, 1);
        chk_hdr("R3", a);
        check("R6", "no fail on read", got_fail, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        nfall = 0; hi_run = 0; hi_cnt = 0; runs = 0; rx_n = 0; m_n = 0; m_cap = '0;

        // R1 reset state
        do_reset();
        check("R1", "cs_n", spi_cs_n, 1);
        check("R1", "sck", spi_sck, 0);
        check("R1", "done", done, 0);
        check("R1", "fail", fail, 0);
        check("R1", "busy", busy, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "mode_valid", mode_valid, 0);

        // R4 wide device with signature
        ee_aw = 24; ee_sig = 1;
        run_op(24'h0, 0);
        check("R4", "done w/o fail", got_fail, 0);
        check("R4", "mode_valid", mode_valid, 1);
        check("R4", "mode_is24", mode_is24, 1);
        check("R4", "one probe window", nfall, 1);
        check("R8", "no rd_valid during probe", rx_n, 0);
        chk_hdr("R3", 24'h000040);

        // R5 narrow device: fallback
        do_reset();
        ee_aw = 16; ee_sig = 1;
        run_op(24'h0, 0);
        check("R5", "mode_valid", mode_valid, 1);
        check("R5", "mode_is24", mode_is24, 0);
        check("R5", "two probe windows", nfall, 2);
        check("R5", "cs gap >= one SCK period", (min_gap >= 2 * HALF) ? 1 : 0, 1);
        check("R8", "no rd_valid during probe", rx_n, 0);
        chk_hdr("R3", 24'h000040);

        // R8/R7 random narrow reads, including address wrap
        chk_read(24'h12FFFE, 4);
        for (int k = 0; k < 6; k++)
            chk_read(24'($urandom), 1 + int'($urandom % 6));

        // R9 zero length
        run_op(24'h000100, 0);
        check("R9", "done on zero length", got_done, 1);
        check("R9", "no chip select", nfall, 0);

        // R11 start while busy
        begin
            logic [23:0] a0;
            a0 = 24'h000321;
            nfall = 0; rx_n = 0; got_done = 0;
            @(negedge clk);
            rd_addr = a0; rd_len = 3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (10) @(negedge clk);
            check("R11", "busy during read", busy, 1);
            rd_addr = 24'h00ABCD; rd_len = 5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!got_done) @(negedge clk);
            repeat (200) @(negedge clk);
            check("R11", "byte count unchanged", rx_n, 3);
            check("R11", "no extra transfer", nfall, 1);
            for (int i = 0; i < 3; i++)
                check("R11", "bytes from first address", longint'(rx_q[i]), longint'(mem_byte(int'(a0) + i)));
            chk_hdr("R11", a0);
        end

        // R6 blank device: both probes miss
        do_reset();
        ee_aw = 24; ee_sig = 0;
        run_op(24'h0, 0);
        check("R6", "done", got_done, 1);
        check("R6", "fail with done", got_fail, 1);
        check("R6", "mode_valid stays 0", mode_valid, 0);
        check("R6", "two probe windows", nfall, 2);

        // R6 retry after failure finds a now-valid wide device
        ee_sig = 1;
        run_op(24'h0, 0);
        check("R6", "retry detects", mode_valid, 1);
        check("R4", "retry mode_is24", mode_is24, 1);
        check("R4", "retry single window", nfall, 1);

        chk_read(24'hFFFFFD, 5);
        for (int k = 0; k < 6; k++)
            chk_read(24'($urandom), 1 + int'($urandom % 6));

        check("R2", "MOSI changed only on SCK fall", mosi_bad, 0);
        check("R10", "SCK high runs observed", (runs > 100) ? 1 : 0, 1);
        check("R10", "SCK high run length", run_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule